// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block buffers words between two unrelated clock domains. The writer pushes words on its own clock and the reader drains them on another. The words sit in a dual-port memory between the two sides. Each side keeps a binary position counter and publishes it in Gray code through a two-stage synchronizer. Each side computes its flags from its own counter and from the synchronized copy of the other side's counter.

The read timing is fixed while master reset is held, from the level of `fwft_sel`. In standard timing a read request moves the next word onto `rdata` one read-clock edge later, and the two flags mean empty (read side) and full (write side). In fall-through timing the oldest word appears on `rdata` without any request and a request discards it. The flags then mean output-ready and input-ready.

A half-full flag is also produced. Master reset clears everything, including the timing choice. Partial reset clears the data and the counters but keeps the timing choice. Retransmit rewinds the reader to the first word written since the last reset, so that everything stored can be read again.

Both resets are synchronous and must be held for at least three cycles of the slower clock. Retransmit is valid only while fewer than the FIFO depth of words have been written since the last reset, and while the writer is idle.

Top module: `dual_clk_fifo`

## Requirements
- R1: While master reset is held and after it is released, `rdata` is 0 and `half_full` is 0. In standard timing `rflag`=1 (empty) and `wflag`=0 (not full). In fall-through timing `rflag`=0 (no word ready) and `wflag`=1 (ready to accept).
- R2: `fwft_sel` (0 = standard, 1 = fall-through) is sampled only while `mrst` is high. Changing it at any other time has no effect on the behaviour.
- R3: Words leave in the order they were written, and the read position never passes the write position.
- R4: In standard timing, a read request while `rflag`=0 places the next word on `rdata` at the same read-clock edge. After the last stored word is taken, `rflag` reads 1 following that edge.
- R5: In fall-through timing, a word written into an empty FIFO appears on `rdata` with `rflag`=1 within 6 read-clock edges after the write edge, without any read request.
- R6: In fall-through timing, a request on the only remaining word clears `rflag` at the very edge that consumes it.
- R7: After the FIFO fills, `wflag` reads 1 in standard timing and 0 in fall-through timing. Further writes are dropped and do not change the stored contents or the write position.
- R8: A read request while empty is ignored: `rdata` holds its value and the next written word is still read correctly.
- R9: `half_full` is 1 exactly when more than half of the memory depth holds unread words, as seen by the write side.
- R10: A partial reset (`prst`) empties the FIFO and clears `rdata`, but keeps the timing mode chosen at the last master reset.
- R11: A retransmit pulse rewinds reading to the first word written since the last reset. In standard timing the next request returns that word. In fall-through timing that word is on `rdata` with `rflag`=1 right after the retransmit edge. Retransmit has priority over a simultaneous request.
- R12: A new master reset replaces the timing mode with the current level of `fwft_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high, seen by both domains |
| prst | input | 1 | Partial reset, synchronous, active high, keeps the timing mode |
| fwft_sel | input | 1 | Timing choice sampled during master reset: 0 standard, 1 fall-through |
| wen | input | 1 | Write request (wclk domain) |
| wdata | input | DW | Word to store |
| ren | input | 1 | Read request (rclk domain) |
| rt | input | 1 | Retransmit pulse (rclk domain) |
| rdata | output | DW | Registered output word |
| rflag | output | 1 | Empty in standard timing, output-ready in fall-through timing |
| wflag | output | 1 | Full in standard timing, input-ready in fall-through timing |
| half_full | output | 1 | More than half of the depth occupied (wclk domain) |

## Verification
The in-RTL properties watch, on every edge, for the following:
- the write side never counts more than the depth of unread words, and a blocked write leaves the write position unchanged;
- an ignored read leaves the read position unchanged, and the reader never passes the synchronized writer;
- output-ready clears on the consuming edge;
- the stored timing mode stays fixed outside master reset.

Only the directed scenarios can show the data values themselves. They show word order through a fill and drain, the fall-through latency bound, the exact location where retransmit resumes, and that partial reset keeps fall-through timing while master reset replaces it.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register of the RAM is the block's data output register.
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          mode_sel,
  input  logic          wen,
  input  logic [AW:0]   rgray_sync,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wflag,
  output logic          half_full
);
  localparam int          DEPTH   = 1 << AW;
  localparam int          HALF    = DEPTH / 2;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_V  = (AW+1)'(HALF);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  rd_mode_e    mode_q;
  logic [AW:0] wbin, wbin_nxt, rbin_s, fill_now, fill_nxt;
  logic        full_q, full_nxt;

  assign push     = wen && !full_q;
  assign wbin_nxt = wbin + {{AW{1'b0}}, push};
  assign rbin_s   = g2b(rgray_sync);
  assign fill_now = wbin - rbin_s;
  assign fill_nxt = wbin_nxt - rbin_s;
  assign full_nxt = (fill_nxt == DEPTH_V);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= rd_mode_e'(mode_sel);
  end

  always_ff @(posedge clk) begin
    if (mrst || prst) begin
      wbin      <= '0;
      wgray     <= '0;
      full_q    <= 1'b0;
      half_full <= 1'b0;
      wflag     <= mrst ? mode_sel : (mode_q == MODE_FWFT);
    end else begin
      wbin      <= wbin_nxt;
      wgray     <= wbin_nxt ^ (wbin_nxt >> 1);
      full_q    <= full_nxt;
      half_full <= (fill_nxt > HALF_V);
      wflag     <= (mode_q == MODE_FWFT) ? !full_nxt : full_nxt;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (mrst || prst)
    fill_now <= DEPTH_V);

  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (mrst || prst)
    (wen && full_q) |=> $stable(wbin));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (mrst)
    !mrst |=> $stable(mode_q));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          mode_sel,
  input  logic          ren,
  input  logic          rt,
  input  logic [AW:0]   wgray_sync,
  output logic          fetch,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          rflag
);
  localparam int          DEPTH   = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE_V   = (AW+1)'(1);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  rd_mode_e    mode_q;
  logic        fwft;
  logic [AW:0] rbin, rbin_nxt, wbin_s;
  logic        empty_q, empty_nxt, ovalid, ovalid_nxt;

  assign fwft   = (mode_q == MODE_FWFT);
  assign wbin_s = g2b(wgray_sync);

  always_comb begin
    fetch      = 1'b0;
    raddr      = rbin[AW-1:0];
    rbin_nxt   = rbin;
    ovalid_nxt = ovalid;
    if (rt) begin
      rbin_nxt   = '0;
      ovalid_nxt = 1'b0;
      if (fwft && (wbin_s != '0)) begin
        fetch      = 1'b1;
        raddr      = '0;
        rbin_nxt   = ONE_V;
        ovalid_nxt = 1'b1;
      end
    end else if (fwft) begin
      if ((!ovalid || ren) && !empty_q) begin
        fetch      = 1'b1;
        rbin_nxt   = rbin + ONE_V;
        ovalid_nxt = 1'b1;
      end else if (ren) begin
        ovalid_nxt = 1'b0;
      end
    end else if (ren && !empty_q) begin
      fetch    = 1'b1;
      rbin_nxt = rbin + ONE_V;
    end
    empty_nxt = (rbin_nxt == wbin_s);
  end

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= rd_mode_e'(mode_sel);
  end

  always_ff @(posedge clk) begin
    if (mrst || prst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_q <= 1'b1;
      ovalid  <= 1'b0;
      rflag   <= mrst ? !mode_sel : !fwft;
    end else begin
      rbin    <= rbin_nxt;
      rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
      empty_q <= empty_nxt;
      ovalid  <= ovalid_nxt;
      rflag   <= fwft ? ovalid_nxt : empty_nxt;
    end
  end

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (mrst || prst)
    (ren && empty_q && !rt) |=> $stable(rbin));

  assert_rd_behind_wr_R3: assert property (@(posedge clk) disable iff (mrst || prst)
    (wbin_s - rbin) <= DEPTH_V);

  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (mrst || prst)
    (fwft && ovalid && ren && empty_q && !rt) |=> !rflag);

  assert_mode_kept_R10: assert property (@(posedge clk) disable iff (mrst)
    !mrst |=> $stable(mode_q));
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  input  logic          ren,
  input  logic          rt,
  output logic [DW-1:0] rdata,
  output logic          rflag,
  output logic          wflag,
  output logic          half_full
);
  localparam int PW = AW + 1;

  logic          push, fetch, any_rst;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

  assign any_rst = mrst || prst;

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .clk(wclk), .mrst(mrst), .prst(prst), .mode_sel(fwft_sel), .wen(wen),
    .rgray_sync(rgray_s), .push(push), .waddr(waddr), .wgray(wgray),
    .wflag(wflag), .half_full(half_full)
  );

  dcf_rd_ctl #(.AW(AW)) u_rd (
    .clk(rclk), .mrst(mrst), .prst(prst), .mode_sel(fwft_sel), .ren(ren), .rt(rt),
    .wgray_sync(wgray_s), .fetch(fetch), .raddr(raddr), .rgray(rgray),
    .rflag(rflag)
  );

  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(any_rst), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(any_rst), .d(rgray), .q(rgray_s));

  dcf_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wclk), .we(push), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .rrst(any_rst), .re(fetch), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/test_dual_clk_fifo.sv
module test_dual_clk_fifo;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          wclk, rclk, mrst, prst, fwft_sel, wen, ren, rt;
  logic [DW-1:0] wdata, rdata;
  logic          rflag, wflag, half_full;
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  bit            done = 0;

  dual_clk_fifo #(.AW(AW), .DW(DW)) i_dual_clk_fifo (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
    .wen(wen), .wdata(wdata), .ren(ren), .rt(rt), .rdata(rdata),
    .rflag(rflag), .wflag(wflag), .half_full(half_full)
  );

  initial begin
    wclk = 0;
    forever #4 wclk = ~wclk;
  end

  initial begin
    rclk = 0;
    #3;
    rclk = 1;
    forever #5 rclk = ~rclk;
  end

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge wclk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_sim();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reset_fifo(input logic mode);
    @(negedge wclk);
    mrst = 1; fwft_sel = mode;
    repeat (6) @(negedge wclk);
    mrst = 0;
    repeat (2) @(negedge wclk);
  endtask

  task automatic push_word(input logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1; wdata = d;
    @(negedge wclk);
    wen = 0;
  endtask

  task automatic rwait(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic read_std(input logic [DW-1:0] exp, input string req);
    @(negedge rclk);
    ren = 1;
    @(posedge rclk);
    #1 chk(req, rdata, exp);
    @(negedge rclk);
    ren = 0;
  endtask

  task automatic read_fwft(input logic [DW-1:0] exp, input string req);
    @(negedge rclk);
    chk({req, " ready"}, rflag, 1);
    chk({req, " data"}, rdata, exp);
    ren = 1;
    @(negedge rclk);
    ren = 0;
  endtask

  // R1 and R12: reset state of standard timing
  task automatic t_reset_std();
    reset_fifo(0);
    chk("R1 empty", rflag, 1);
    chk("R1 full", wflag, 0);
    chk("R1 half", half_full, 0);
    chk("R1 rdata", rdata, 0);
  endtask

  // R3 and R4: order and one-edge read latency
  task automatic t_std_basic();
    for (int i = 0; i < 5; i++) push_word(8'h30 + 8'(i));
    rwait(8);
    chk("R4 not empty", rflag, 0);
    for (int i = 0; i < 5; i++) read_std(8'h30 + 8'(i), "R3 order");
    chk("R4 empty after last", rflag, 1);
  endtask

  // R8: read while empty is ignored
  task automatic t_std_underflow();
    @(negedge rclk);
    ren = 1;
    rwait(3);
    ren = 0;
    chk("R8 rdata held", rdata, 8'h34);
    chk("R8 still empty", rflag, 1);
    push_word(8'hC3);
    rwait(8);
    read_std(8'hC3, "R8 next word");
  endtask

  // R7 and R9: fill, overflow, half-full
  task automatic t_std_full();
    for (int i = 0; i < DEPTH + 3; i++) begin
      push_word(8'h80 + 8'(i));
      if (i == DEPTH / 2 - 1) chk("R9 at half", half_full, 0);
      if (i == DEPTH / 2)     chk("R9 above half", half_full, 1);
      if (i == DEPTH - 2)     chk("R7 not yet full", wflag, 0);
    end
    chk("R7 full", wflag, 1);
    rwait(8);
    for (int i = 0; i < DEPTH; i++) read_std(8'h80 + 8'(i), "R7 contents");
    chk("R7 extra writes dropped", rflag, 1);
    repeat (8) @(negedge wclk);
    chk("R9 half clears", half_full, 0);
    chk("R7 full clears", wflag, 0);
  endtask

  // R2: mode select ignored outside master reset
  task automatic t_mode_ignore();
    reset_fifo(0);
    @(negedge wclk);
    fwft_sel = 1;
    push_word(8'h5A);
    rwait(8);
    chk("R2 no fall-through", rdata, 0);
    chk("R2 standard flag", rflag, 0);
    read_std(8'h5A, "R2 standard read");
    fwft_sel = 0;
  endtask

  // R11: retransmit in standard timing
  task automatic t_retx_std();
    reset_fifo(0);
    for (int i = 0; i < 4; i++) push_word(8'h10 + 8'(i));
    rwait(8);
    for (int i = 0; i < 4; i++) read_std(8'h10 + 8'(i), "R11 first pass");
    @(negedge rclk);
    rt = 1; ren = 1;
    @(negedge rclk);
    rt = 0; ren = 0;
    chk("R11 rewind not empty", rflag, 0);
    chk("R11 request ignored under rt", rdata, 8'h13);
    read_std(8'h10, "R11 std replay 0");
    read_std(8'h11, "R11 std replay 1");
  endtask

  // R1, R5, R6, R12: fall-through timing
  task automatic t_fwft_basic();
    bit seen;
    reset_fifo(1);
    chk("R12 fwft ready flag", rflag, 0);
    chk("R1 input ready", wflag, 1);
    push_word(8'hE0);
    seen = 0;
    for (int k = 0; k < 6 && !seen; k++) begin
      @(posedge rclk);
      #1 if (rflag) seen = 1;
    end
    chk("R5 fall-through latency", seen, 1);
    chk("R5 head word", rdata, 8'hE0);
    push_word(8'hE1);
    push_word(8'hE2);
    rwait(8);
    read_fwft(8'hE0, "R5 w0");
    read_fwft(8'hE1, "R3 w1");
    @(negedge rclk);
    chk("R6 last ready", rflag, 1);
    chk("R6 last data", rdata, 8'hE2);
    ren = 1;
    @(posedge rclk);
    #1 chk("R6 drop same edge", rflag, 0);
    @(negedge rclk);
    ren = 0;
  endtask

  // R11: retransmit in fall-through timing (continues from t_fwft_basic)
  task automatic t_retx_fwft();
    @(negedge rclk);
    rt = 1;
    @(posedge rclk);
    #1 chk("R11 fwft zero latency flag", rflag, 1);
    chk("R11 fwft zero latency data", rdata, 8'hE0);
    @(negedge rclk);
    rt = 0;
    read_fwft(8'hE0, "R11 fwft w0");
    read_fwft(8'hE1, "R11 fwft w1");
    read_fwft(8'hE2, "R11 fwft w2");
    @(negedge rclk);
    chk("R11 fwft drained", rflag, 0);
  endtask

  // R7: fall-through capacity and input-ready
  task automatic t_fwft_full();
    reset_fifo(1);
    for (int i = 0; i < DEPTH + 2; i++) push_word(8'h40 + 8'(i));
    rwait(10);
    chk("R7 input not ready", wflag, 0);
    for (int i = 0; i <= DEPTH; i++) read_fwft(8'h40 + 8'(i), "R7 fwft contents");
    rwait(2);
    chk("R7 fwft drop extra", rflag, 0);
  endtask

  // R10: partial reset keeps the mode
  task automatic t_prst();
    push_word(8'h21);
    push_word(8'h22);
    rwait(8);
    @(negedge wclk);
    prst = 1; fwft_sel = 0;
    repeat (6) @(negedge wclk);
    prst = 0;
    repeat (2) @(negedge wclk);
    chk("R10 cleared flag", rflag, 0);
    chk("R10 ready kept", wflag, 1);
    chk("R10 rdata cleared", rdata, 0);
    chk("R10 half cleared", half_full, 0);
    push_word(8'h77);
    rwait(8);
    chk("R10 still fall-through", rflag, 1);
    chk("R10 head word", rdata, 8'h77);
  endtask

  initial begin
    mrst = 1; prst = 0; fwft_sel = 0; wen = 0; ren = 0; rt = 0; wdata = '0;
    t_reset_std();
    t_std_basic();
    t_std_underflow();
    t_std_full();
    t_mode_ignore();
    t_retx_std();
    t_fwft_basic();
    t_retx_fwft();
    t_fwft_full();
    t_prst();
    finish_sim();
  end
endmodule